// File: doc/BRIEF.md
# Valid/Ready Pipeline Register Slice

This block sits on one valid/ready streaming channel, between a source and a sink. It shortens the timing paths on that channel and keeps the handshake rules the same on both sides. Neither side needs extra wait states or any change in behaviour. A transfer moves on a side whenever valid and ready are both high there at a rising clock edge. The two sides handshake independently of each other.

The `MODE` parameter picks one of three variants:

- **Full.** A two-entry ping-pong store with an output multiplexer. The upstream ready and the downstream valid and data are all decoded from flops only.
- **Forward.** One registered stage drives valid and data toward the sink. The upstream ready is combinational on the downstream ready.
- **Reverse.** One skid register makes the upstream ready a flop output. Valid and data pass straight through while the skid register is empty.

Reset is synchronous and active low.

Top module: `pipe_slice`

## Requirements
- R1: In every mode, transfers leave downstream in the order they were accepted upstream, with none lost and none repeated.
- R2: In full mode (`MODE`=0), `up_ready` is high exactly when fewer than two transfers are held, and a full slice stays full while `dn_ready` is low.
- R3: In full mode, `dn_valid` is high exactly when at least one transfer is held. A rise of `dn_valid` follows an upstream transfer in the previous cycle.
- R4: With `up_valid` and `dn_ready` both held high, every mode moves one transfer per clock cycle.
- R5: While `dn_valid` is high and `dn_ready` is low, `dn_valid` stays high and `dn_data` does not change in the next cycle.
- R6: In forward mode (`MODE`=1), `dn_valid` is high exactly when one transfer is held, and `up_ready` equals (nothing held) OR `dn_ready`.
- R7: In reverse mode (`MODE`=2), `up_ready` is high exactly when the skid register is empty. `dn_valid` equals `up_valid` OR (skid full). With the skid register empty, `dn_data` equals `up_data`.
- R8: A clock edge with `rst_n` low empties all storage. After it, `up_ready` is high, and in full and forward modes `dn_valid` is low.
- R9: Once the source stops and the sink is always ready, every accepted transfer is delivered, leaving nothing held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Source offers a transfer |
| up_ready | output | 1 | Slice can take a transfer |
| up_data | input | DATA_W | Payload from the source |
| dn_valid | output | 1 | Slice offers a transfer |
| dn_ready | input | 1 | Sink can take a transfer |
| dn_data | output | DATA_W | Payload toward the sink |

## Verification
The bench builds three copies side by side, one per `MODE` value (0, 1 and 2), each with `DATA_W`=8. An 8-bit payload carrying a running sequence number exposes any drop, duplication or reordering of transfers. It also lets the bench check each output against the number of transfers accepted minus the number delivered.

Every pairing of a 4-cycle periodic valid pattern with a 4-cycle periodic ready pattern is applied, 256 pairings in all. These reach every fill level of each variant, every simultaneous accept-and-issue case, and long stalls. A reset while the slices are full, and a final drain, cover reset clearing and the no-loss rule.

// File: rtl/regslice_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the valid/ready register slice.
// Assumes: nothing; the package only holds the variant selector type.
package regslice_pkg;
    // Variant selector; the numeric values are used in the requirements.
    typedef enum logic [1:0] {
        SLICE_FULL = 2'd0,
        SLICE_FWD  = 2'd1,
        SLICE_REV  = 2'd2
    } slice_mode_e;
endpackage

// File: rtl/slice_full.sv
`timescale 1ns/1ps
// Full register slice: a two-entry ping-pong store with an output multiplexer.
// up_ready, dn_valid and dn_data depend on flops only, so no same-cycle input
// reaches any output. Order is kept by one-bit write and read pointers.
// Assumes: the source holds up_valid and up_data until it sees up_ready.
module slice_full #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    localparam int SLOTS = 2;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  full_q;
    logic              wr_ptr_q;
    logic              rd_ptr_q;
    logic              wr_en;
    logic              rd_en;

    // Handshake decode on each side.
    assign wr_en = up_valid && up_ready;
    assign rd_en = dn_valid && dn_ready;

    // Occupancy flags and pointers; each pointer toggles on its own side's transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= '0;
            wr_ptr_q <= 1'b0;
            rd_ptr_q <= 1'b0;
        end else begin
            if (wr_en) begin
                full_q[wr_ptr_q] <= 1'b1;
                wr_ptr_q         <= ~wr_ptr_q;
            end
            if (rd_en) begin
                full_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q         <= ~rd_ptr_q;
            end
        end
    end

    // One payload register per slot, loaded when the write pointer selects it.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr_q == i[0])) begin
                slot_q[i] <= up_data;
            end
        end
    end

    // Flop-only decode of the handshake outputs and the output multiplexer.
    assign up_ready = ~&full_q;
    assign dn_valid = full_q[rd_ptr_q];
    assign dn_data  = slot_q[rd_ptr_q];
endmodule

// File: rtl/slice_fwd.sv
`timescale 1ns/1ps
// Forward register slice: one registered stage for valid and payload.
// up_ready is combinational on dn_ready, so the stage refills in the same
// cycle it empties and keeps a rate of one transfer per clock.
// Assumes: the sink may hold dn_ready low for any number of cycles.
module slice_fwd #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    // The stage may load when it is empty or is being emptied in this cycle.
    assign up_ready = !valid_q || dn_ready;

    // Valid flag of the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (up_ready) begin
            valid_q <= up_valid;
        end
    end

    // Payload register, loaded on each upstream transfer.
    always_ff @(posedge clk) begin
        if (up_valid && up_ready) begin
            data_q <= up_data;
        end
    end

    assign dn_valid = valid_q;
    assign dn_data  = data_q;
endmodule

// File: rtl/slice_rev.sv
`timescale 1ns/1ps
// Reverse register slice: a skid register makes up_ready a flop output.
// When the sink stalls while a transfer is offered and the skid register is
// empty, the transfer is parked there. Otherwise valid and data pass straight on.
// Assumes: the source holds up_valid and up_data until it sees up_ready.
module slice_rev #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              skid_full_q;
    logic [DATA_W-1:0] skid_data_q;

    // Skid occupancy: fill on a stalled pass-through, drain when the sink takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skid_full_q <= 1'b0;
        end else if (!skid_full_q) begin
            skid_full_q <= up_valid && !dn_ready;
        end else if (dn_ready) begin
            skid_full_q <= 1'b0;
        end
    end

    // Skid payload, captured when a stalled transfer is parked.
    always_ff @(posedge clk) begin
        if (!skid_full_q && up_valid && !dn_ready) begin
            skid_data_q <= up_data;
        end
    end

    assign up_ready = !skid_full_q;
    assign dn_valid = skid_full_q || up_valid;
    assign dn_data  = skid_full_q ? skid_data_q : up_data;
endmodule

// File: rtl/pipe_slice.sv
`timescale 1ns/1ps
// Top of the valid/ready pipeline register slice. MODE selects the variant
// that is built: full, forward or reverse.
// Assumes: one clock domain, synchronous active-low reset.
module pipe_slice #(
    parameter int                        DATA_W = 8,
    parameter regslice_pkg::slice_mode_e MODE   = regslice_pkg::SLICE_FULL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    // Variant selection.
    if (MODE == regslice_pkg::SLICE_FULL) begin : g_full
        slice_full #(.DATA_W(DATA_W)) u_core (
            .clk(clk), .rst_n(rst_n),
            .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
            .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
        );
    end else if (MODE == regslice_pkg::SLICE_FWD) begin : g_fwd
        slice_fwd #(.DATA_W(DATA_W)) u_core (
            .clk(clk), .rst_n(rst_n),
            .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
            .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
        );
    end else begin : g_rev
        slice_rev #(.DATA_W(DATA_W)) u_core (
            .clk(clk), .rst_n(rst_n),
            .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
            .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
        );
    end
endmodule

// File: rtl/pipe_slice_chk.sv
`timescale 1ns/1ps
// Protocol checker for pipe_slice; it sees only the block's ports.
// Assumes: it is attached to every pipe_slice instance by the bind below.
module pipe_slice_chk #(
    parameter int                        DATA_W = 8,
    parameter regslice_pkg::slice_mode_e MODE   = regslice_pkg::SLICE_FULL
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic [DATA_W-1:0] up_data,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [DATA_W-1:0] dn_data
);
    // R5: a stalled offer keeps its valid and its payload.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // R8: after a reset edge the slice can accept.
    a_r8_ready_after_reset: assert property (@(posedge clk)
        !rst_n |=> up_ready);

    if (MODE == regslice_pkg::SLICE_FULL) begin : g_full
        // R2: backpressure only when both slots hold data.
        a_r2_block_means_data: assert property (@(posedge clk) disable iff (!rst_n)
            !up_ready |-> dn_valid);
        // R2: a full slice stays full while the sink stalls.
        a_r2_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
            (!up_ready && !dn_ready) |=> !up_ready);
        // R3: a new offer downstream comes from an earlier upstream transfer.
        a_r3_rise_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dn_valid) |-> $past(up_valid));
        // R8: nothing offered after a reset edge.
        a_r8_empty_full: assert property (@(posedge clk)
            !rst_n |=> !dn_valid);
    end else if (MODE == regslice_pkg::SLICE_FWD) begin : g_fwd
        // R6: upstream is blocked only by a held, stalled transfer.
        a_r6_ready_path: assert property (@(posedge clk) disable iff (!rst_n)
            !up_ready |-> (dn_valid && !dn_ready));
        // R6: registered valid follows an upstream transfer.
        a_r6_rise_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dn_valid) |-> $past(up_valid));
        // R8: nothing offered after a reset edge.
        a_r8_empty_fwd: assert property (@(posedge clk)
            !rst_n |=> !dn_valid);
    end else begin : g_rev
        // R7: a blocked source means a parked transfer is on offer.
        a_r7_skid_offer: assert property (@(posedge clk) disable iff (!rst_n)
            !up_ready |-> dn_valid);
        // R7: with the skid register empty the offer passes straight through.
        a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (up_ready && up_valid) |-> (dn_valid && dn_data == up_data));
    end
endmodule

bind pipe_slice pipe_slice_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
);

// File: tb/pipe_slice_harness.sv
`timescale 1ns/1ps
// Drives one pipe_slice with periodic valid/ready patterns and checks every
// cycle against an occupancy model: accepted count minus delivered count.
module pipe_slice_harness #(
    parameter regslice_pkg::slice_mode_e MODE = regslice_pkg::SLICE_FULL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] vsel,
    input  logic [3:0] rsel,
    output int         checks,
    output int         errors,
    output int         issued,
    output int         outstanding
);
    localparam int DW = 8;

    logic          up_valid = 1'b0;
    logic          up_ready;
    logic [DW-1:0] up_data = '0;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [DW-1:0] dn_data;

    int            sent = 0;
    int            got = 0;
    int            cyc = 0;
    int            held;
    bit            pending = 0;
    bit            prev_stall = 0;
    bit            rst_seen = 0;
    logic [DW-1:0] prev_data = '0;

    initial begin
        checks = 0;
        errors = 0;
        issued = 0;
    end

    assign outstanding = sent - got;

    pipe_slice #(.DATA_W(DW), .MODE(MODE)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s mode %0d cycle %0d: actual %0d expected %0d",
                     req, int'(MODE), cyc, act, exp);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            up_valid   = 1'b0;
            dn_ready   = 1'b0;
            sent       = 0;
            got        = 0;
            pending    = 0;
            prev_stall = 0;
            #2;
            if (rst_seen) begin
                chk(up_ready == 1'b1, "R8 up_ready", up_ready, 1);
                if (MODE != regslice_pkg::SLICE_REV)
                    chk(dn_valid == 1'b0, "R8 dn_valid", dn_valid, 0);
            end
            rst_seen = 1;
        end else begin
            rst_seen = 0;
            up_valid = pending ? 1'b1 : (run && vsel[cyc[1:0]]);
            up_data  = sent[DW-1:0];
            dn_ready = run ? rsel[cyc[1:0]] : 1'b1;
            #2;
            held = sent - got;
            if (prev_stall)
                chk(dn_valid && dn_data == prev_data, "R5 hold", int'(dn_data), int'(prev_data));
            if (MODE == regslice_pkg::SLICE_FULL) begin
                chk(up_ready == (held < 2), "R2 up_ready", up_ready, int'(held < 2));
                chk(dn_valid == (held > 0), "R3 dn_valid", dn_valid, int'(held > 0));
            end else if (MODE == regslice_pkg::SLICE_FWD) begin
                chk(dn_valid == (held == 1), "R6 dn_valid", dn_valid, int'(held == 1));
                chk(up_ready == (held == 0 || dn_ready), "R6 up_ready",
                    up_ready, int'(held == 0 || dn_ready));
            end else begin
                chk(up_ready == (held == 0), "R7 up_ready", up_ready, int'(held == 0));
                chk(dn_valid == (up_valid || held == 1), "R7 dn_valid",
                    dn_valid, int'(up_valid || held == 1));
                if (held == 0 && up_valid)
                    chk(dn_data == up_data, "R7 pass data", int'(dn_data), int'(up_data));
            end
            if (dn_valid && dn_ready) begin
                chk(dn_data == got[DW-1:0], "R1 order", int'(dn_data), got & 255);
                got++;
                issued++;
            end
            if (up_valid && up_ready) begin
                sent++;
                pending = 0;
            end else begin
                pending = up_valid;
            end
            prev_stall = dn_valid && !dn_ready;
            prev_data  = dn_data;
            cyc++;
        end
    end
endmodule

// File: tb/pipe_slice_test.sv
`timescale 1ns/1ps
// Bench: one slice per variant, swept over every pair of 4-cycle valid and
// ready patterns, then throughput, drain and mid-traffic reset phases.
module pipe_slice_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [3:0] vsel = 4'h0;
    logic [3:0] rsel = 4'h0;
    int         chk_n [3];
    int         err_n [3];
    int         iss_n [3];
    int         out_n [3];
    int         top_checks = 0;
    int         top_errors = 0;
    int         base [3];
    bit         finished = 0;

    always #4 clk = ~clk;

    pipe_slice_harness #(.MODE(regslice_pkg::SLICE_FULL)) h_full (
        .clk(clk), .rst_n(rst_n), .run(run), .vsel(vsel), .rsel(rsel),
        .checks(chk_n[0]), .errors(err_n[0]), .issued(iss_n[0]), .outstanding(out_n[0]));
    pipe_slice_harness #(.MODE(regslice_pkg::SLICE_FWD)) h_fwd (
        .clk(clk), .rst_n(rst_n), .run(run), .vsel(vsel), .rsel(rsel),
        .checks(chk_n[1]), .errors(err_n[1]), .issued(iss_n[1]), .outstanding(out_n[1]));
    pipe_slice_harness #(.MODE(regslice_pkg::SLICE_REV)) h_rev (
        .clk(clk), .rst_n(rst_n), .run(run), .vsel(vsel), .rsel(rsel),
        .checks(chk_n[2]), .errors(err_n[2]), .issued(iss_n[2]), .outstanding(out_n[2]));

    task automatic tchk(input bit ok, input string req, input int act, input int exp);
        top_checks++;
        if (!ok) begin
            top_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        int c;
        int e;
        c = top_checks + chk_n[0] + chk_n[1] + chk_n[2];
        e = top_errors + err_n[0] + err_n[1] + err_n[2];
        $display("  CHECKS %0d ERRORS %0d", c, e);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Exhaustive sweep over 4-cycle periodic patterns (R1, R2, R3, R5, R6, R7).
        run = 1'b1;
        for (int v = 0; v < 16; v++) begin
            for (int r = 0; r < 16; r++) begin
                vsel = v[3:0];
                rsel = r[3:0];
                repeat (12) @(negedge clk);
            end
        end
        // R4: steady one-per-clock rate with both sides always ready.
        vsel = 4'hF;
        rsel = 4'hF;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 3; i++) base[i] = iss_n[i];
        repeat (40) @(negedge clk);
        for (int i = 0; i < 3; i++)
            tchk(iss_n[i] - base[i] == 40, "R4 throughput", iss_n[i] - base[i], 40);
        // R9: drain delivers everything accepted.
        run = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++)
            tchk(out_n[i] == 0, "R9 drained", out_n[i], 0);
        // R8: fill under a stalled sink, then reset while holding data.
        run = 1'b1;
        vsel = 4'hF;
        rsel = 4'h0;
        repeat (6) @(negedge clk);
        tchk(out_n[0] == 2, "R2 full slice holds two", out_n[0], 2);
        tchk(out_n[1] == 1, "R6 forward holds one", out_n[1], 1);
        tchk(out_n[2] == 1, "R7 reverse holds one", out_n[2], 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++)
            tchk(iss_n[i] - base[i] >= 40, "R8 no stale output", iss_n[i] - base[i], 40);
        // Short run after reset, then final drain (R1, R9).
        run = 1'b1;
        vsel = 4'hB;
        rsel = 4'h6;
        repeat (20) @(negedge clk);
        run = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++)
            tchk(out_n[i] == 0, "R9 final drain", out_n[i], 0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            tchk(1'b0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end
endmodule